// File: doc/BRIEF.md
# Countdown Timer Bank with Status and Interrupt Register

This block holds five countdown timers that share a divided clock and one control/status byte. Each timer counts down from a reload value held in its own write-only register. When it reaches zero it reloads and raises a sticky terminal-count flag. A CPU reaches the block over a byte-wide peripheral bus that has separate read and write strobes and one address. The block drives a single level-sensitive interrupt request.

The status byte acts differently on read and on write. A read returns the sticky flags. It clears exactly the flags it returned, so an event that arrives during the read is kept. A write to the same address loads the per-timer interrupt enables and the shared clock-run bit. None of these written bits can be read back.

The timers are numbered 0 to 4. Each one owns a fixed bit of the status byte and a fixed reload address:

| Timer | Status bit | Reload address |
|-------|------------|----------------|
| 0 | 1 | 0xA3 |
| 1 | 4 | 0xA9 |
| 2 | 5 | 0xAB |
| 3 | 6 | 0xAD |
| 4 | 7 | 0xAF |

Top module: `tmr_bank_csr`

## Requirements
- R1: Synchronous active-low reset clears all flags, enables, the run bit, the divider, the counters and the read-data register. After reset the interrupt output is 0 and a status read returns 0x00.
- R2: A bus read strobe at address 0xA0 latches the status byte onto `bus_rdata_o` after the clock edge, and the byte holds until the next such read. Status bits 1, 4, 5, 6 and 7 carry the terminal-count flags of timers 0 to 4 in that order. Bits 0, 2 and 3 always read 0.
- R3: A status read clears only the flags that were set in the byte it returned. A terminal-count event in the same cycle as the read leaves its flag set, so no event is lost.
- R4: A write to 0xA0 loads the enable of timers 0 to 4 from write-data bits 1, 4, 5, 6 and 7. Write-data bits 2 and 3 have no effect. Enables never appear in read data.
- R5: Write-data bit 0 of a write to 0xA0 sets the shared run bit; 1 runs the timers and 0 stops them. While the run bit is 0 the counters do not advance and no flag sets.
- R6: While the run bit is 1, the divider makes one count tick every two clocks. Timer i counts down once per tick. On the tick at which its count is 0, the timer loads its reload value and, one clock later, pulses its terminal-count event for one clock. Its flag therefore sets every 2*(reload+1) clocks.
- R7: `irq_o` is 1 whenever some flag and its enable are both 1, and 0 otherwise. A flag cleared by a read before it is enabled produces no request.
- R8: Writing a reload register does not restart its counter. The new value is first used at that timer's next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 8 | Peripheral bus address |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Status byte latched by the last status read |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench drives the following stimulus patterns:
- Continuous read strobes while one timer runs. The spacing of the returned flags measures the reload period, and a change of reload value made mid-count shows whether the counter restarted.
- Reads on alternate cycles, run once at each phase. One phase lines a read up with a terminal-count event while that flag is already set, which separates a clear that swallows the event from one that keeps it.
- Enable and run writes with the clock stopped. These show that flags persist without an enable and that the request follows the enable alone.
- Writes that set only the reserved bits, which must change nothing.

// File: rtl/tmr_pkg.sv
// Package: shared address map and bit placement for the timer bank.
// Assumes at most five timers; positions beyond that are not defined.
package tmr_pkg;

    localparam logic [7:0] CSR_ADDR = 8'hA0;

    // Status/enable bit that belongs to timer idx
    function automatic int flag_pos(input int idx);
        return (idx == 0) ? 1 : idx + 3;
    endfunction

    // Bus address of the reload register of timer idx
    function automatic logic [7:0] tc_addr(input int idx);
        return (idx == 0) ? 8'hA3 : 8'(8'hA7 + 2 * idx);
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
// Module: shared divide-by-two prescaler.
// Emits a one-cycle tick every second clock while run_i is high.
// The phase is held, not reset, when run_i drops.
module tmr_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    logic half_q;

    // Toggle the phase bit while the timers run
    always_ff @(posedge clk) begin
        if (!rst_n)     half_q <= 1'b0;
        else if (run_i) half_q <= ~half_q;
    end

    assign tick_o = run_i & half_q;

endmodule

// File: rtl/tmr_down.sv
// Module: one reloading countdown timer.
// Counts down on each tick. On the tick where the count is zero it
// reloads and, one clock later, pulses evt_o for a single clock.
// A reload write only changes the value used at the next reload.
module tmr_down #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_we_i,
    input  logic [CNT_W-1:0] load_d_i,
    output logic             evt_o
);

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_q;
    logic             evt_q;
    logic             at_zero;

    assign at_zero = (cnt_q == '0);

    // Hold the reload value written over the bus
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '0;
        else if (load_we_i) reload_q <= load_d_i;
    end

    // Count down per tick, reloading on the zero tick
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_i) cnt_q <= at_zero ? reload_q : cnt_q - 1'b1;
    end

    // Register the terminal-count event for one clock
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= tick_i & at_zero;
    end

    assign evt_o = evt_q;

endmodule

// File: rtl/tmr_csr.sv
// Module: shared control/status register.
// Reads return the sticky flags and clear only the flags captured by that
// read; an event in the same cycle wins over the clear.
// Writes load the per-timer enables and the run bit. The request output is
// the OR of enabled flags.
module tmr_csr
    import tmr_pkg::*;
#(
    parameter int N_TMR  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N_TMR-1:0]  evt_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              run_o,
    output logic [N_TMR-1:0]  flag_o
);

    logic [N_TMR-1:0]  flag_q;
    logic [N_TMR-1:0]  en_q;
    logic              run_q;
    logic [DATA_W-1:0] rdata_q;
    logic [N_TMR-1:0]  grabbed;
    logic [DATA_W-1:0] packed_flags;

    // Flags taken by a read in this cycle
    assign grabbed = rd_i ? flag_q : '0;

    // Place each flag on its own status bit
    always_comb begin
        packed_flags = '0;
        for (int i = 0; i < N_TMR; i++) begin
            packed_flags[flag_pos(i)] = flag_q[i];
        end
    end

    // Sticky flags: clear what was read, set on new events
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~grabbed) | evt_i;
    end

    // Enables and run bit loaded by a register write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            run_q <= 1'b0;
        end else if (wr_i) begin
            for (int i = 0; i < N_TMR; i++) begin
                en_q[i] <= wdata_i[flag_pos(i)];
            end
            run_q <= wdata_i[0];
        end
    end

    // Read data captured on the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= packed_flags;
    end

    assign rdata_o = rdata_q;
    assign irq_o   = |(flag_q & en_q);
    assign run_o   = run_q;
    assign flag_o  = flag_q;

endmodule

// File: rtl/tmr_bank_csr.sv
// Module: top of the timer bank.
// Decodes the byte-wide bus, shares one prescaler, and builds one
// countdown timer per bank slot. Reads and writes are single-cycle strobes
// and are assumed never to be asserted together.
module tmr_bank_csr
    import tmr_pkg::*;
#(
    parameter int N_TMR  = 5,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] CSR_SEL = ADDR_W'(CSR_ADDR);

    logic             csr_rd;
    logic             csr_wr;
    logic             run;
    logic             tick;
    logic [N_TMR-1:0] evt_vec;
    logic [N_TMR-1:0] flag_vec;
    logic [N_TMR-1:0] load_we;

    assign csr_rd = bus_rd_i & (bus_addr_i == CSR_SEL);
    assign csr_wr = bus_wr_i & (bus_addr_i == CSR_SEL);

    tmr_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        // Reload-register write decode for this timer
        assign load_we[g] = bus_wr_i & (bus_addr_i == ADDR_W'(tc_addr(g)));

        tmr_down #(.CNT_W(CNT_W)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick),
            .load_we_i (load_we[g]),
            .load_d_i  (bus_wdata_i[CNT_W-1:0]),
            .evt_o     (evt_vec[g])
        );
    end

    tmr_csr #(.N_TMR(N_TMR), .DATA_W(DATA_W)) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (csr_rd),
        .wr_i    (csr_wr),
        .wdata_i (bus_wdata_i),
        .evt_i   (evt_vec),
        .rdata_o (bus_rdata_o),
        .irq_o   (irq_o),
        .run_o   (run),
        .flag_o  (flag_vec)
    );

endmodule

// File: rtl/tmr_bank_chk.sv
// Module: property checker for the timer bank, bound to the top.
// Watches the bus decode, the flags, the events and the request output.
module tmr_bank_chk #(
    parameter int N_TMR  = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_rd,
    input logic              csr_wr,
    input logic [DATA_W-1:0] rdata,
    input logic              irq,
    input logic [N_TMR-1:0]  flags,
    input logic [N_TMR-1:0]  evt,
    input logic              run
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata[0] == 1'b0) && (rdata[3:2] == 2'b00)); // R2

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(csr_rd) |-> (rdata == $past(rdata))); // R2

    AST_FLAG_CLEAR_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags) & ~flags)) |-> $past(csr_rd)); // R3

    AST_EVT_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flags & $past(evt)) == $past(evt))); // R3

    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> (evt == '0)); // R5

    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(csr_rd) || $past(csr_wr))); // R7

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(csr_wr) || $past(|evt))); // R7

endmodule

bind tmr_bank_csr tmr_bank_chk #(.N_TMR(N_TMR), .DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .csr_rd (csr_rd),
    .csr_wr (csr_wr),
    .rdata  (bus_rdata_o),
    .irq    (irq_o),
    .flags  (flag_vec),
    .evt    (evt_vec),
    .run    (run)
);

// File: tb/sim_tmr_bank_csr.sv
module sim_tmr_bank_csr;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tmr_bank_csr u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (bus_addr),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit ended  = 1'b0;
    bit cmp_on = 1'b0;
    int hits[$];

    // status bit and reload address of each timer, from the requirements
    int pos[5] = '{1, 4, 5, 6, 7};
    int tca[5] = '{'hA3, 'hA9, 'hAB, 'hAD, 'hAF};

    // reference model state
    bit m_div, m_run;
    int m_rdata;
    int m_cnt[5], m_tc[5];
    bit m_evt[5], m_flag[5], m_en[5];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    function automatic bit m_irq();
        bit r = 1'b0;
        for (int i = 0; i < 5; i++) r = r | (m_flag[i] & m_en[i]);
        return r;
    endfunction

    always @(posedge clk) cyc++;

    // behavioural reference, advanced once per clock
    always @(posedge clk) begin : mdl
        bit tick, rdc, wrc;
        bit nevt[5];
        int ncnt[5];
        if (!rst_n) begin
            m_div = 0; m_run = 0; m_rdata = 0;
            for (int i = 0; i < 5; i++) begin
                m_cnt[i] = 0; m_tc[i] = 0; m_evt[i] = 0; m_flag[i] = 0; m_en[i] = 0;
            end
        end else begin
            tick = m_run && m_div;
            rdc  = bus_rd && bus_addr == 8'hA0;
            wrc  = bus_wr && bus_addr == 8'hA0;
            for (int i = 0; i < 5; i++) begin
                nevt[i] = tick && m_cnt[i] == 0;
                ncnt[i] = !tick ? m_cnt[i] : (m_cnt[i] == 0 ? m_tc[i] : m_cnt[i] - 1);
            end
            if (rdc) begin
                m_rdata = 0;
                for (int i = 0; i < 5; i++) if (m_flag[i]) m_rdata = m_rdata | (1 << pos[i]);
            end
            for (int i = 0; i < 5; i++) m_flag[i] = (m_flag[i] && !rdc) || m_evt[i];
            if (m_run) m_div = !m_div;
            if (wrc) begin
                m_run = bus_wdata[0];
                for (int i = 0; i < 5; i++) m_en[i] = bus_wdata[pos[i]];
            end
            for (int i = 0; i < 5; i++) begin
                if (bus_wr && bus_addr == tca[i][7:0]) m_tc[i] = int'(bus_wdata);
                m_evt[i] = nevt[i];
                m_cnt[i] = ncnt[i];
            end
        end
    end

    // compare outputs with the model every cycle
    always @(negedge clk) begin
        if (cmp_on) begin
            check(bus_rdata == m_rdata[7:0], "R2/R3", "rdata vs model", bus_rdata, m_rdata);
            check(irq == m_irq(), "R7", "irq vs model", irq, m_irq());
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = a[7:0]; bus_wdata = d[7:0]; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        bus_addr = 8'hA0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // continuous reads; stamps cycles whose returned byte has bit b set
    task automatic poll(input int b, input int n, input bit stop_hit);
        bit done = 1'b0;
        @(negedge clk);
        bus_addr = 8'hA0; bus_rd = 1'b1;
        for (int k = 0; k < n && !done; k++) begin
            @(negedge clk);
            if (k > 0 && bus_rdata[b]) begin
                hits.push_back(cyc);
                if (stop_hit) done = 1'b1;
            end
        end
        bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int h0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(irq == 1'b0, "R1", "irq in reset", irq, 0);
        check(bus_rdata == 8'h00, "R1", "rdata in reset", bus_rdata, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        rd();
        check(bus_rdata == 8'h00, "R1", "status after reset", bus_rdata, 0);

        // reload values with the clock stopped, then enables but no run
        wr('hA3, 3); wr('hA9, 0); wr('hAB, 7); wr('hAD, 1); wr('hAF, 2);
        wr('hA0, 'hF2);
        idle(40);
        check(irq == 1'b0, "R5", "irq while stopped", irq, 0);
        rd();
        check(bus_rdata == 8'h00, "R5", "no flags while stopped", bus_rdata, 0);
        check(bus_rdata == 8'h00, "R4", "enables invisible on read", bus_rdata, 0);

        // period of timer 0 with reload 3
        wr('hA0, 'h03);
        hits.delete();
        poll(1, 40, 1'b0);
        check(hits.size() >= 4, "R6", "flag count", hits.size(), 4);
        for (int k = 1; k < hits.size(); k++)
            check(hits[k] - hits[k-1] == 8, "R6", "flag spacing", hits[k] - hits[k-1], 8);

        // reload change mid-count
        hits.delete();
        poll(1, 20, 1'b1);
        h0 = (hits.size() > 0) ? hits[hits.size()-1] : 0;
        wr('hA3, 5);
        hits.delete();
        poll(1, 40, 1'b0);
        check(hits.size() >= 3, "R8", "flag count", hits.size(), 3);
        if (hits.size() >= 3) begin
            check(hits[0] - h0 == 8, "R8", "old reload kept", hits[0] - h0, 8);
            check(hits[1] - hits[0] == 12, "R8", "new reload used", hits[1] - hits[0], 12);
            check(hits[2] - hits[1] == 12, "R8", "new reload steady", hits[2] - hits[1], 12);
        end

        // request follows enabled flag and read clear
        idle(15);
        wr('hA0, 'h02);
        idle(4);
        check(irq == 1'b1, "R7", "irq with enabled flag", irq, 1);
        rd();
        check(bus_rdata[1] == 1'b1, "R7", "flag returned", bus_rdata[1], 1);
        check((bus_rdata & 8'h0D) == 8'h00, "R2", "reserved bits", bus_rdata & 8'h0D, 0);
        check(irq == 1'b0, "R7", "irq after read", irq, 0);

        // flags set without enables; then enable writes
        wr('hA0, 'h01);
        idle(30);
        wr('hA0, 'h00);
        idle(4);
        check(irq == 1'b0, "R7", "flags without enable", irq, 0);
        wr('hA0, 'hF0);
        check(irq == 1'b1, "R4", "enables of timers 1-4", irq, 1);
        wr('hA0, 'h0C);
        check(irq == 1'b0, "R4", "bits 2,3 ignored", irq, 0);
        rd();
        check(bus_rdata == 8'hF2, "R2", "all flags placed", bus_rdata, 'hF2);
        check(irq == 1'b0, "R3", "cleared flags", irq, 0);

        // reads on alternate cycles at both phases against fast timer 1
        wr('hA0, 'h11);
        for (int k = 0; k < 12; k++) rd();
        idle(1);
        for (int k = 0; k < 12; k++) rd();
        wr('hA0, 'h10);
        idle(4);
        rd();
        check(irq == 1'b0, "R3", "irq after final read", irq, 0);
        idle(5);
        finish_run();
    end

endmodule